// File: doc/BRIEF.md
# Bus-Request Block Transfer Controller

This block moves a block of words between one peripheral and memory without the processor copying each word. The processor first programs it as an ordinary slave: while the bus grant input is low, a select line together with a two-bit register index gives read and write access to a start address, a remaining-word count and a control word. Writing the control word with its go bit set arms the channel.

Once armed, each request from the peripheral causes the controller to raise bus request and wait. When the processor answers with bus grant, the controller spends one cycle per word. In that cycle it drives the memory address, drives either the memory write strobe (peripheral to memory) or the memory read strobe (memory to peripheral), and acknowledges the peripheral. After each word the address steps up by one and the count steps down by one. The controller then releases the bus and waits for the next request. When the count reaches zero, the channel goes idle, sets a done flag and, if enabled, raises an interrupt. The interrupt stays high until the processor writes the control word again. The processor can read the count at any time to see how many words remain.

Top module: `bdma_ctrl`

## Requirements
- R1: Register access happens only when `host_sel` is 1 and `bus_grant` is 0. `host_reg` 0 selects the address, 1 the word count, 2 the control word, and 3 reads as zero. `host_rdata` is zero unless a read is selected, and a write made while `bus_grant` is 1 changes nothing.
- R2: Control word layout. Bit 0 is go when written and busy (channel not idle) when read. Bit 1 is direction (1 = peripheral to memory, memory write; 0 = memory to peripheral, memory read). Bit 2 is interrupt enable. Bit 3 is the read-only done flag. All other bits read as zero.
- R3: Until a go command is written, `bus_req` stays low whatever `periph_req` does.
- R4: When the channel is armed, `periph_req` high at a clock edge makes `bus_req` high from the next cycle. The channel then holds `bus_req` and drives no strobe until `bus_grant` is high.
- R5: In a transfer cycle with `bus_grant` high, `mem_addr` equals the address register, exactly one of `mem_wr` and `mem_rd` is high as the direction bit selects, and `periph_ack` is high. This lasts for exactly one cycle per word.
- R6: After each word, the address rises by one and the count falls by one. `bus_req` drops, and the channel samples `periph_req` again.
- R7: When the last word completes, the channel goes idle, `bus_req` falls, the done flag sets, and `irq` rises if interrupt enable is 1. `irq` stays low if interrupt enable is 0.
- R8: The done flag, and with it `irq`, holds until the processor writes the control word. That write clears it.
- R9: A go command written while the count is zero sets the done flag on the next edge and never raises `bus_req`.
- R10: Writing the control word with bit 0 clear while the channel is busy stops it at the next edge. `bus_req` drops, and the address and count keep their values.
- R11: Whenever no transfer cycle is under way, `mem_addr` is zero and `mem_rd`, `mem_wr` and `periph_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Processor selects this controller |
| host_reg | input | 2 | Register index |
| host_rd | input | 1 | Processor register read |
| host_wr | input | 1 | Processor register write |
| host_wdata | input | DATA_W | Write data from processor |
| host_rdata | output | DATA_W | Read data to processor |
| bus_req | output | 1 | Request for the memory bus |
| bus_grant | input | 1 | Processor has released the bus |
| mem_addr | output | ADDR_W | Memory address during a transfer |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| periph_req | input | 1 | Peripheral requests one word |
| periph_ack | output | 1 | Word is being transferred |
| irq | output | 1 | Block complete interrupt |

## Verification
The hardest state to reach from the ports is a stop command that lands while `bus_req` is high and grant is still being withheld. At that moment the channel owns a pending request, yet the processor still owns the bus. The bench reaches it by arming a block, raising the peripheral request, holding `bus_grant` low for several cycles, and then writing the control word with go clear. It then checks that `bus_req` falls and that the count is unchanged. A second hard case is a go command with a zero count, which must finish without touching the bus. The bench produces it by clearing the count before arming.

// File: rtl/bdma_pkg.sv
package bdma_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_REQ   = 2'd2,
      ST_XFER  = 2'd3
   } bdma_state_e;

   localparam logic [1:0] REG_ADDR  = 2'd0;
   localparam logic [1:0] REG_COUNT = 2'd1;
   localparam logic [1:0] REG_CTRL  = 2'd2;

   localparam int CTL_GO   = 0;
   localparam int CTL_DIR  = 1;
   localparam int CTL_IEN  = 2;
   localparam int CTL_DONE = 3;
   localparam int CTL_W    = 4;
endpackage

// File: rtl/bdma_regfile.sv
module bdma_regfile
   import bdma_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_addr,
   input  logic              wr_cnt,
   input  logic              wr_ctrl,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_en,
   input  logic [1:0]        rd_sel,
   input  logic              step,
   input  logic              finish,
   input  logic              busy,
   output logic [ADDR_W-1:0] addr_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              dir_q,
   output logic              ien_q,
   output logic              pend_q,
   output logic              cnt_zero,
   output logic              cnt_one,
   output logic [DATA_W-1:0] rdata
);
   localparam int ADDR_PAD = DATA_W - ADDR_W;
   localparam int CNT_PAD  = DATA_W - CNT_W;

   initial begin
      assert (DATA_W >= ADDR_W) else $error("DATA_W must cover ADDR_W");
      assert (DATA_W >= CNT_W)  else $error("DATA_W must cover CNT_W");
      assert (DATA_W >= CTL_W)  else $error("DATA_W must cover control bits");
   end

   logic [DATA_W-1:0] addr_ext, cnt_ext, ctrl_ext;

   generate
      if (ADDR_PAD == 0) begin : g_addr_full
         assign addr_ext = addr_q;
      end else begin : g_addr_pad
         assign addr_ext = {{ADDR_PAD{1'b0}}, addr_q};
      end
      if (CNT_PAD == 0) begin : g_cnt_full
         assign cnt_ext = cnt_q;
      end else begin : g_cnt_pad
         assign cnt_ext = {{CNT_PAD{1'b0}}, cnt_q};
      end
   endgenerate

   assign ctrl_ext = DATA_W'({pend_q, ien_q, dir_q, busy});
   assign cnt_zero = (cnt_q == '0);
   assign cnt_one  = (cnt_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         cnt_q  <= '0;
         dir_q  <= 1'b0;
         ien_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (wr_addr)   addr_q <= wdata[ADDR_W-1:0];
         else if (step) addr_q <= addr_q + ADDR_W'(1);
         if (wr_cnt)    cnt_q  <= wdata[CNT_W-1:0];
         else if (step) cnt_q  <= cnt_q - CNT_W'(1);
         if (wr_ctrl) begin
            dir_q <= wdata[CTL_DIR];
            ien_q <= wdata[CTL_IEN];
         end
         if (finish)       pend_q <= 1'b1;
         else if (wr_ctrl) pend_q <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         case (rd_sel)
            REG_ADDR:  rdata = addr_ext;
            REG_COUNT: rdata = cnt_ext;
            REG_CTRL:  rdata = ctrl_ext;
            default:   rdata = '0;
         endcase
      end
   end

   // R8
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !wr_ctrl) |=> pend_q);

   // R6
   step_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !wr_addr) |=> (addr_q == $past(addr_q) + ADDR_W'(1)));
endmodule

// File: rtl/bdma_fsm.sv
module bdma_fsm
   import bdma_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic go_cmd,
   input  logic halt_cmd,
   input  logic cnt_zero,
   input  logic cnt_one,
   input  logic periph_req,
   input  logic bus_grant,
   output logic bus_req,
   output logic xfer,
   output logic step,
   output logic finish,
   output logic busy
);
   bdma_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE:  if (go_cmd && !cnt_zero) st_d = ST_ARMED;
         ST_ARMED: if (periph_req) st_d = ST_REQ;
         ST_REQ:   if (bus_grant) st_d = ST_XFER;
         ST_XFER:  if (bus_grant) st_d = cnt_one ? ST_IDLE : ST_ARMED;
         default:  st_d = ST_IDLE;
      endcase
      if (st_q != ST_IDLE && halt_cmd) st_d = ST_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign busy    = (st_q != ST_IDLE);
   assign bus_req = (st_q == ST_REQ) || (st_q == ST_XFER);
   assign xfer    = (st_q == ST_XFER);
   assign step    = xfer && bus_grant;
   assign finish  = ((st_q == ST_IDLE) && go_cmd && cnt_zero) || (step && cnt_one);

   // R9
   zero_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && go_cmd && cnt_zero) |=> (st_q == ST_IDLE && !bus_req));

   // R7
   last_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cnt_one) |=> (st_q == ST_IDLE));

   // R4
   grant_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_REQ && !bus_grant && !halt_cmd) |=> (st_q == ST_REQ));

   // R10
   halt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && halt_cmd) |=> !bus_req);
endmodule

// File: rtl/bdma_ctrl.sv
module bdma_ctrl
   import bdma_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_sel,
   input  logic [1:0]        host_reg,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              bus_req,
   input  logic              bus_grant,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   input  logic              periph_req,
   output logic              periph_ack,
   output logic              irq
);
   logic host_en, wr_ctrl, go_cmd, halt_cmd;
   logic xfer, step, finish, busy, active;
   logic cnt_zero, cnt_one, dir_q, ien_q, pend_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  cnt_q;

   assign host_en  = host_sel && !bus_grant;
   assign wr_ctrl  = host_en && host_wr && (host_reg == REG_CTRL);
   assign go_cmd   = wr_ctrl && host_wdata[CTL_GO];
   assign halt_cmd = wr_ctrl && !host_wdata[CTL_GO];

   bdma_regfile #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_addr  (host_en && host_wr && (host_reg == REG_ADDR)),
      .wr_cnt   (host_en && host_wr && (host_reg == REG_COUNT)),
      .wr_ctrl  (wr_ctrl),
      .wdata    (host_wdata),
      .rd_en    (host_en && host_rd),
      .rd_sel   (host_reg),
      .step     (step),
      .finish   (finish),
      .busy     (busy),
      .addr_q   (addr_q),
      .cnt_q    (cnt_q),
      .dir_q    (dir_q),
      .ien_q    (ien_q),
      .pend_q   (pend_q),
      .cnt_zero (cnt_zero),
      .cnt_one  (cnt_one),
      .rdata    (host_rdata)
   );

   bdma_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .go_cmd     (go_cmd),
      .halt_cmd   (halt_cmd),
      .cnt_zero   (cnt_zero),
      .cnt_one    (cnt_one),
      .periph_req (periph_req),
      .bus_grant  (bus_grant),
      .bus_req    (bus_req),
      .xfer       (xfer),
      .step       (step),
      .finish     (finish),
      .busy       (busy)
   );

   assign active     = xfer && bus_grant;
   assign mem_addr   = active ? addr_q : '0;
   assign mem_wr     = active && dir_q;
   assign mem_rd     = active && !dir_q;
   assign periph_ack = active;
   assign irq        = pend_q && ien_q;

   // R11
   strobe_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> (bus_req && bus_grant));

   // R5
   ack_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      periph_ack |-> (mem_rd ^ mem_wr));

   // R6
   one_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      periph_ack |=> !periph_ack);
endmodule

// File: tb/bdma_ctrl_tb.sv
module bdma_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_sel = 0, host_rd = 0, host_wr = 0;
   logic [1:0]  host_reg = 0;
   logic [15:0] host_wdata = 0;
   logic [15:0] host_rdata;
   logic        bus_req, bus_grant = 0;
   logic [15:0] mem_addr;
   logic        mem_rd, mem_wr, periph_req = 0, periph_ack, irq;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   bdma_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_reg(host_reg),
      .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .bus_req(bus_req), .bus_grant(bus_grant),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .periph_req(periph_req), .periph_ack(periph_ack), .irq(irq)
   );

   // behavioural reference: phase 0 idle, 1 waiting for request, 2 asking, 3 moving
   int          m_ph;
   logic [15:0] m_addr, m_cnt;
   bit          m_dir, m_ien, m_done, m_acked;

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_ph = 0; m_addr = 0; m_cnt = 0; m_dir = 0; m_ien = 0; m_done = 0; m_acked = 0;
      end else begin
         bit hw, cw, fin;
         hw = host_sel && host_wr && !bus_grant;
         cw = hw && host_reg == 2'd2;
         fin = 0;
         m_acked = (m_ph == 3) && bus_grant;
         if (m_ph != 0 && cw && !host_wdata[0]) m_ph = 0;
         else if (m_ph == 0) begin
            if (cw && host_wdata[0]) begin
               if (m_cnt == 0) fin = 1; else m_ph = 1;
            end
         end else if (m_ph == 1) begin
            if (periph_req) m_ph = 2;
         end else if (m_ph == 2) begin
            if (bus_grant) m_ph = 3;
         end else if (bus_grant) begin
            if (m_cnt == 1) begin m_ph = 0; fin = 1; end else m_ph = 1;
            m_addr = m_addr + 1;
            m_cnt = m_cnt - 1;
         end
         if (hw && host_reg == 2'd0) m_addr = host_wdata;
         if (hw && host_reg == 2'd1) m_cnt = host_wdata;
         if (cw) begin m_dir = host_wdata[1]; m_ien = host_wdata[2]; end
         if (fin) m_done = 1; else if (cw) m_done = 0;
      end
   end

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic bit m_busreq();
      return m_ph == 2 || m_ph == 3;
   endfunction

   always @(negedge clk) begin
      #1;
      if (rst_n && !finished) begin
         bit act;
         logic [15:0] er;
         act = (m_ph == 3) && bus_grant;
         er = 0;
         if (host_sel && host_rd && !bus_grant) begin
            case (host_reg)
               2'd0: er = m_addr;
               2'd1: er = m_cnt;
               2'd2: er = {12'd0, m_done, m_ien, m_dir, m_ph != 0};
               default: er = 0;
            endcase
         end
         chk("R4", "bus_req", bus_req, m_busreq());
         chk("R5", "mem_addr", mem_addr, act ? m_addr : 16'd0);
         chk("R5", "mem_wr", mem_wr, act && m_dir);
         chk("R5", "mem_rd", mem_rd, act && !m_dir);
         chk("R11", "periph_ack", periph_ack, act);
         chk("R7", "irq", irq, m_done && m_ien);
         chk("R1", "host_rdata", host_rdata, er);
      end
   end

   task automatic idle_bus();
      host_sel = 0; host_wr = 0; host_rd = 0;
   endtask

   task automatic hwrite(input logic [1:0] r, input logic [15:0] d);
      @(negedge clk);
      host_sel = 1; host_wr = 1; host_rd = 0; host_reg = r; host_wdata = d;
      @(negedge clk);
      idle_bus();
   endtask

   task automatic hread(input string tag, input logic [1:0] r, input logic [15:0] exp);
      @(negedge clk);
      host_sel = 1; host_rd = 1; host_wr = 0; host_reg = r;
      #2 chk(tag, "register read", host_rdata, exp);
      @(negedge clk);
      idle_bus();
   endtask

   // grant follows the modelled request after gdel cycles; device pauses gap cycles after each word
   task automatic run(input int n, input int gdel, input int gap);
      int waitc = 0;
      int gapc = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (m_acked) gapc = gap;
         periph_req = (gapc == 0);
         if (gapc > 0) gapc--;
         if (m_busreq()) begin
            waitc++;
            bus_grant = (waitc > gdel);
         end else begin
            waitc = 0;
            bus_grant = 0;
         end
      end
      @(negedge clk);
      periph_req = 0; bus_grant = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      #1 chk("R11", "reset outputs", {bus_req, mem_rd, mem_wr, periph_ack, irq}, 0);
      hread("R2", 2'd2, 16'h0000);

      // R3: requests before a go command are ignored
      periph_req = 1;
      repeat (5) @(negedge clk);
      #1 chk("R3", "bus_req without go", bus_req, 0);
      periph_req = 0;

      // R1: access while grant is high has no effect
      @(negedge clk);
      bus_grant = 1; host_sel = 1; host_wr = 1; host_reg = 2'd0; host_wdata = 16'hFFFF;
      @(negedge clk);
      host_wr = 0; host_rd = 1;
      #1 chk("R1", "read with grant high", host_rdata, 0);
      @(negedge clk);
      idle_bus(); bus_grant = 0;
      hread("R1", 2'd0, 16'h0000);
      hread("R1", 2'd3, 16'h0000);

      // block 1: peripheral to memory, interrupt on, slow grant
      hwrite(2'd0, 16'h0100);
      hwrite(2'd1, 16'd3);
      hwrite(2'd2, 16'h0007);
      hread("R2", 2'd2, 16'h0007);
      run(30, 2, 0);
      #1 chk("R7", "irq after block", irq, 1);
      hread("R6", 2'd1, 16'd0);
      hread("R6", 2'd0, 16'h0103);
      hread("R2", 2'd2, 16'h000E);
      repeat (3) @(negedge clk);
      #1 chk("R8", "irq held", irq, 1);
      hwrite(2'd2, 16'h0004);
      #1 chk("R8", "irq cleared by control write", irq, 0);

      // block 2: memory to peripheral, interrupt off, slow device
      hwrite(2'd0, 16'h2000);
      hwrite(2'd1, 16'd4);
      hwrite(2'd2, 16'h0001);
      run(60, 0, 3);
      #1 chk("R7", "irq stays low when disabled", irq, 0);
      hread("R7", 2'd2, 16'h0008);
      hread("R6", 2'd0, 16'h2004);

      // R9: go with zero count
      hwrite(2'd1, 16'd0);
      hwrite(2'd2, 16'h0005);
      #1 chk("R9", "irq on zero count", irq, 1);
      periph_req = 1;
      repeat (4) @(negedge clk);
      #1 chk("R9", "no bus_req on zero count", bus_req, 0);
      periph_req = 0;

      // R10: stop while waiting for grant
      hwrite(2'd0, 16'h3000);
      hwrite(2'd1, 16'd5);
      hwrite(2'd2, 16'h0003);
      periph_req = 1;
      repeat (4) @(negedge clk);
      #1 chk("R4", "bus_req held waiting for grant", bus_req, 1);
      periph_req = 0;
      hwrite(2'd2, 16'h0002);
      #1 chk("R10", "bus_req after stop", bus_req, 0);
      hread("R10", 2'd1, 16'd5);
      hread("R10", 2'd0, 16'h3000);

      // fast device, longer block
      hwrite(2'd0, 16'hFFFE);
      hwrite(2'd1, 16'd6);
      hwrite(2'd2, 16'h0007);
      run(50, 1, 0);
      hread("R6", 2'd0, 16'h0004);
      hread("R7", 2'd1, 16'd0);

      repeat (2) @(negedge clk);
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      wait (cycles > 20000);
      if (!finished) begin
         finished = 1;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d cycles", cycles, 20000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule